// File: doc/BRIEF.md
# Temperature Sample Averaging Filter

This block smooths processor temperature readings by keeping a short circular history of samples and reporting their mean on request. A separate bus controller fetches each reading. At every poll strobe it presents the two received bytes of the raw relative-temperature word and a flag that says whether the read succeeded. The block turns a good reading into kelvin and writes it into the next history slot. A failed read leaves a marker in that slot that means "no sample".

When a result is requested, the block returns the integer mean of the slots that hold a sample. It refuses to answer when fewer than two slots hold a sample, so one bad maximum reading taken during power-up cannot by itself cross a thermal trip point. It also refuses while the processor is reported unpowered. The answer appears one clock after the request as a single pulse on exactly one of three flags. The average word holds its value until the next valid answer.

Top module: `thermal_avg_filter`

## Requirements
- R1: After reset every history slot holds 300 K, the write position is slot 0, so a request with power present returns 300 with `avg_valid`.
- R2: With conversion on (`CONVERT`=1), the raw word is {`byte_hi`,`byte_lo`}. The stored value is `TJMAX_C` + 273 − (((−raw) mod 65536) >> 6), a signed value. Example: raw 0xF380 with `TJMAX_C`=100 gives 323, and raw 0x0000 gives 373.
- R3: A poll with `read_ok` low stores −1. Any slot holding a negative value is left out of both the sum and the count.
- R4: Each poll writes the current slot and then advances the write position by one, wrapping modulo `DEPTH` (4), so the fifth poll overwrites the first poll's slot.
- R5: The average is the integer quotient of the sum of the valid slots divided by the number of valid slots.
- R6: With power present and fewer than two valid slots, a request yields `err_few` and no `avg_valid`. `avg_out` keeps its previous value.
- R7: A request while `powered` is low yields `err_unpowered` only, whatever the history holds.
- R8: Each request produces, in the next cycle, a pulse on exactly one of `avg_valid`, `err_few` and `err_unpowered`. All three are low in a cycle that follows no request, and `avg_out` changes only on a valid answer.
- R9: When a poll and a request fall in the same cycle, the answer is computed from the history as it stood before that poll's write.
- R10: With conversion off (`CONVERT`=0), a good read stores the raw word {`byte_hi`,`byte_lo`} unchanged as a non-negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll | input | 1 | One-cycle strobe: a new reading is present |
| read_ok | input | 1 | The reading with this poll succeeded |
| byte_lo | input | 8 | First received byte (low half of raw word) |
| byte_hi | input | 8 | Second received byte (high half of raw word) |
| powered | input | 1 | Processor power present |
| req | input | 1 | One-cycle strobe: compute the average |
| avg_out | output | 16 | Registered average |
| avg_valid | output | 1 | Pulse: avg_out updated with a valid average |
| err_few | output | 1 | Pulse: fewer than two valid slots |
| err_unpowered | output | 1 | Pulse: request while unpowered |

## Verification
The history write made by a poll and the averaging made by a request can fall in the same clock. The bench raises both strobes together, with a reading that would change the mean. It expects the answer computed from the earlier history (R9), and then expects a following request to include the new sample. A second instance with conversion off receives the same stimulus, so the raw-storage variant is checked against its own model in every scenario.

// File: rtl/thermal_avg_filter.sv
module thermal_avg_filter #(
  parameter int DEPTH   = 4,
  parameter int TJMAX_C = 100,
  parameter bit CONVERT = 1'b1,
  parameter int INIT_K  = 300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        poll,
  input  logic        read_ok,
  input  logic [7:0]  byte_lo,
  input  logic [7:0]  byte_hi,
  input  logic        powered,
  input  logic        req,
  output logic [15:0] avg_out,
  output logic        avg_valid,
  output logic        err_few,
  output logic        err_unpowered
);
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int SUMW = 16 + CW;

  logic signed [16:0] slot [DEPTH];
  logic [IW-1:0]      wr_idx;
  logic [15:0]        raw;
  logic signed [16:0] conv, sample;
  logic [SUMW-1:0]    sum, quot, divisor;
  logic [CW-1:0]      cnt;

  assign raw = {byte_hi, byte_lo};

  generate
    if (CONVERT) begin : g_kelvin
      logic [15:0] neg;
      assign neg  = ~raw + 16'd1;
      assign conv = 17'(TJMAX_C + 273) - {7'd0, neg[15:6]};
    end else begin : g_raw
      assign conv = {1'b0, raw};
    end
  endgenerate

  assign sample = read_ok ? conv : -17'sd1;

  always_comb begin
    sum = '0;
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!slot[i][16]) begin
        sum = sum + SUMW'(slot[i][15:0]);
        cnt = cnt + CW'(1);
      end
    end
  end

  assign divisor = (cnt == '0) ? SUMW'(1) : SUMW'(cnt);
  assign quot    = sum / divisor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= 17'(INIT_K);
      wr_idx <= '0;
    end else if (poll) begin
      slot[wr_idx] <= sample;
      wr_idx       <= wr_idx + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_out       <= '0;
      avg_valid     <= 1'b0;
      err_few       <= 1'b0;
      err_unpowered <= 1'b0;
    end else begin
      avg_valid     <= req && powered && (cnt >= CW'(2));
      err_few       <= req && powered && (cnt < CW'(2));
      err_unpowered <= req && !powered;
      if (req && powered && (cnt >= CW'(2))) avg_out <= quot[15:0];
    end
  end

  p_one_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({avg_valid, err_few, err_unpowered}));
  p_answer_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (avg_valid || err_few || err_unpowered));
  p_quiet_without_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !(avg_valid || err_few || err_unpowered));
  p_hold_avg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(avg_out));
  p_unpowered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !powered) |=> err_unpowered);
  p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !poll |=> $stable(wr_idx));
  p_few_keeps_avg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_few |-> $stable(avg_out));
endmodule

// File: tb/thermal_avg_filter_test.sv
module thermal_avg_filter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic poll = 0, read_ok = 0, powered = 1, req = 0;
  logic [7:0] byte_lo = 0, byte_hi = 0;
  logic [15:0] avg_a, avg_b;
  logic va, fa, ua, vb, fb, ub;
  int errors = 0, checks = 0;
  int m1 [4];
  int m2 [4];
  int idx = 0;
  int last1 = 0, last2 = 0;

  always #2 clk = ~clk;

  thermal_avg_filter #(.CONVERT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .poll(poll), .read_ok(read_ok),
    .byte_lo(byte_lo), .byte_hi(byte_hi), .powered(powered), .req(req),
    .avg_out(avg_a), .avg_valid(va), .err_few(fa), .err_unpowered(ua));

  thermal_avg_filter #(.CONVERT(1'b0)) uut_raw (
    .clk(clk), .rst_n(rst_n), .poll(poll), .read_ok(read_ok),
    .byte_lo(byte_lo), .byte_hi(byte_hi), .powered(powered), .req(req),
    .avg_out(avg_b), .avg_valid(vb), .err_few(fb), .err_unpowered(ub));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int to_kelvin(input int raw);
    int neg;
    neg = (65536 - raw) % 65536;
    return 100 + 273 - (neg / 64);
  endfunction

  task automatic model_write(input bit ok, input int raw);
    m1[idx] = ok ? to_kelvin(raw) : -1;
    m2[idx] = ok ? raw : -1;
    idx = (idx + 1) % 4;
  endtask

  task automatic expect_one(input string tag, input int m[4], input int last,
                            input logic [15:0] avg, input logic v, input logic f,
                            input logic u, output int new_last);
    int s = 0, c = 0;
    for (int i = 0; i < 4; i++) if (m[i] >= 0) begin s += m[i]; c++; end
    new_last = last;
    if (!powered) begin
      check(u && !v && !f, {tag, " R7 unpowered flag"}, {29'd0, v, f, u}, 1);
      check(avg == 16'(last), {tag, " R7 avg held"}, avg, last);
    end else if (c < 2) begin
      check(f && !v && !u, {tag, " R6 few flag"}, {29'd0, v, f, u}, 2);
      check(avg == 16'(last), {tag, " R6 avg held"}, avg, last);
    end else begin
      new_last = s / c;
      check(v && !f && !u, {tag, " R8 valid flag"}, {29'd0, v, f, u}, 4);
      check(avg == 16'(new_last), {tag, " R5 average"}, avg, new_last);
    end
  endtask

  task automatic do_poll(input bit ok, input int raw);
    @(negedge clk);
    poll = 1; read_ok = ok; byte_hi = raw[15:8]; byte_lo = raw[7:0];
    @(negedge clk);
    poll = 0;
    model_write(ok, raw);
  endtask

  task automatic do_req(input string tag);
    @(negedge clk);
    req = 1;
    @(negedge clk);
    req = 0;
    expect_one({tag, " conv"}, m1, last1, avg_a, va, fa, ua, last1);
    expect_one({tag, " raw R10"}, m2, last2, avg_b, vb, fb, ub, last2);
    @(negedge clk);
    check(!(va || fa || ua), {tag, " R8 quiet after"}, {29'd0, va, fa, ua}, 0);
  endtask

  task automatic t_reset;
    check(!(va || fa || ua), "R1 flags low at reset", {29'd0, va, fa, ua}, 0);
    do_req("R1 reset history");
  endtask

  task automatic t_convert;
    do_poll(1, 16'hF380);
    check(m1[0] == 323, "R2 model kelvin", m1[0], 323);
    do_req("R2 converted sample");
  endtask

  task automatic t_failed;
    do_poll(0, 0);
    do_poll(0, 0);
    do_req("R3 two failed reads");
    do_poll(0, 0);
    do_req("R3 R6 one valid slot");
  endtask

  task automatic t_wrap;
    do_poll(1, 16'h0000);
    do_req("R4 wrap overwrites slot0");
    do_poll(1, 16'hF380);
    do_req("R4 second lap");
  endtask

  task automatic t_unpowered;
    powered = 0;
    do_req("R7 power low");
    powered = 1;
  endtask

  task automatic t_collide;
    int s1, s2;
    @(negedge clk);
    poll = 1; read_ok = 1; byte_hi = 8'h00; byte_lo = 8'h00; req = 1;
    @(negedge clk);
    poll = 0; req = 0;
    expect_one("R9 same-cycle conv", m1, last1, avg_a, va, fa, ua, s1);
    expect_one("R9 same-cycle raw", m2, last2, avg_b, vb, fb, ub, s2);
    last1 = s1; last2 = s2;
    model_write(1, 0);
    do_req("R9 after collision");
  endtask

  task automatic t_raw_store;
    do_poll(1, 16'h1234);
    do_poll(1, 16'h00FF);
    do_req("R10 raw words");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m1[i] = 300; m2[i] = 300; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_convert();
    t_failed();
    t_wrap();
    t_unpowered();
    t_collide();
    t_raw_store();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule